// File: doc/BRIEF.md
# Digital I/O Channel Bank

A bank of general-purpose digital I/O channels behind a simple register bus. Every channel owns a one-bit output latch and a registered drive stage. The drive stage chooses between the latch, an externally routed alternate signal and a protected fallback value that applies while a system-wide safe condition is asserted. The drive stage feeds an open-drain pull-down enable, so the host-side sense is active-high and the pin is active-low. The bank never drives a pin high. Outside the block, the pin is modelled as a wired-AND of this pull-down and any external pull-down, with a pull-up.

The pin level is captured into an input register only on a sample strobe. It then passes through a debounce filter with a programmable length that is shared by all channels. The filtered level is what the host reads back. An edge detector watches the filtered level. Each channel has its own enables for rising and falling edges, and an enabled edge sets a sticky capture flag. An interrupt line is raised while any enabled flag is set. Every writable register takes a per-bit write mask, so software can set or clear individual channels atomically.

The bus address is `{reg_index[3:0], word}`, where `word` is the low `WSEL_W` bits. Word `w` carries channels `w*BW` up to `w*BW+BW-1`, and channel `c` of that word sits in data bit `c - w*BW`. Register indices are: 0 output latch, 1 alternate-source select, 2 safe value, 3 safe enable, 4 rise enable, 5 fall enable, 6 capture flags (write 1 to clear), 7 filtered level (read-only), 8 control (bit 0 = safe-register write enable, word 0 only), and 9 debounce length (word 0 only).

Top module: `dio_bank`

## Requirements
- R1: After reset, every register reads 0, no pull-down is enabled and the interrupt is low.
- R2: A write changes only the bits whose mask bit is 1. `pad_pull_low[c]` equals the channel's selected drive value one clock after the register update, so a 1 in the output latch pulls the pin low.
- R3: With debounce length 0, the level read at index 7 is the logical inverse of the sampled pin. With the wired-AND pin model, this gives the output latch OR'd with the external pull-downs.
- R4: A channel whose alternate-select bit is 1 drives `alt_src[c]` in place of its output latch.
- R5: While `safe_active` is 1, a channel whose safe-enable bit is 1 drives its safe value. Other channels, and all channels while `safe_active` is 0, are unaffected.
- R6: Writes to index 2 and index 3 are ignored while control bit 0 is 0.
- R7: With debounce length N>0, a differing sample is accepted on the Nth strobe after the strobe that captured it. A sample equal to the current level before that point restarts the count.
- R8: A 0-to-1 change of the filtered level sets the capture flag if rise enable is set. A 1-to-0 change sets it if fall enable is set. Flags hold until they are cleared.
- R9: Writing 1 (with mask 1) to a capture bit clears it. Writing 0, or a masked-off bit, leaves it unchanged.
- R10: `irq` is the OR of all capture flags whose channel has a rise or fall enable set.
- R11: The pin is sampled only when `sample_tick` is 1. Pin changes between strobes do not reach the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register index and word select |
| bus_wdata | input | BW | Write data |
| bus_wmask | input | BW | Per-bit write mask |
| bus_rdata | output | BW | Combinational read data |
| alt_src | input | NCH | Alternate routed drive sources |
| safe_active | input | 1 | System safe condition |
| sample_tick | input | 1 | Pin sample strobe |
| pad_in | input | NCH | Physical pin levels |
| pad_pull_low | output | NCH | Open-drain pull-down enables |
| irq | output | 1 | Capture interrupt |

## Verification
The bench sweeps masked writes across both words of an eight-channel bank. It also crosses latch values with external pull-downs, which catches an inverted readback or a drive path with a lost mask. The debounce test checks the exact acceptance strobe and a bounce that must restart the count, so an off-by-one counter or a filter that never restarts shows up as a level that appears early or leaks through. The capture tests use partial clear masks and change the enables after flags are already set, which exposes set/clear priority errors and an interrupt that ignores the enables. Protected safe writes are read back after the safe-register write enable is dropped.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int REG_IDX_W = 4;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_DRV     = 4'd0,
        REG_ALTSEL  = 4'd1,
        REG_SAFEVAL = 4'd2,
        REG_SAFEMSK = 4'd3,
        REG_RISE    = 4'd4,
        REG_FALL    = 4'd5,
        REG_CAPT    = 4'd6,
        REG_LEVEL   = 4'd7,
        REG_CTRL    = 4'd8,
        REG_DEBLEN  = 4'd9
    } reg_idx_e;

    function automatic int words_for(input int n, input int w);
        return (n + w - 1) / w;
    endfunction

    function automatic int sel_width(input int nw);
        return (nw > 1) ? $clog2(nw) : 1;
    endfunction

endpackage

// File: rtl/dio_regfile.sv
module dio_regfile
    import dio_pkg::*;
#(
    parameter int NCH    = 48,
    parameter int BW     = 32,
    parameter int CNT_W  = 8,
    parameter int WSEL_W = 1,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    input  logic [BW-1:0]     bus_wmask,
    output logic [BW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    level,
    input  logic [NCH-1:0]    cap,
    output logic [NCH-1:0]    drv_o,
    output logic [NCH-1:0]    altsel_o,
    output logic [NCH-1:0]    safe_val_o,
    output logic [NCH-1:0]    safe_msk_o,
    output logic [NCH-1:0]    rise_en_o,
    output logic [NCH-1:0]    fall_en_o,
    output logic              swe_o,
    output logic [CNT_W-1:0]  deblen_o,
    output logic [NCH-1:0]    cap_clr_o
);

    localparam int DB_BITS = (CNT_W < BW) ? CNT_W : BW;

    typedef struct packed {
        logic [NCH-1:0]   drv;
        logic [NCH-1:0]   altsel;
        logic [NCH-1:0]   safe_val;
        logic [NCH-1:0]   safe_msk;
        logic [NCH-1:0]   rise_en;
        logic [NCH-1:0]   fall_en;
        logic             swe;
        logic [CNT_W-1:0] deblen;
    } rf_t;

    rf_t                rf_d, rf_q;
    reg_idx_e           sel;
    logic [WSEL_W-1:0]  word;
    logic [NCH-1:0]     clr_d;
    logic [NCH-1:0]     rd_vec;

    assign sel  = reg_idx_e'(bus_addr[ADDR_W-1:WSEL_W]);
    assign word = bus_addr[WSEL_W-1:0];

    always_comb begin
        rf_d  = rf_q;
        clr_d = '0;
        if (bus_we) begin
            for (int i = 0; i < NCH; i++) begin
                if ((i / BW) == int'(word) && bus_wmask[i % BW]) begin
                    case (sel)
                        REG_DRV:     rf_d.drv[i]     = bus_wdata[i % BW];
                        REG_ALTSEL:  rf_d.altsel[i]  = bus_wdata[i % BW];
                        REG_SAFEVAL: if (rf_q.swe) rf_d.safe_val[i] = bus_wdata[i % BW];
                        REG_SAFEMSK: if (rf_q.swe) rf_d.safe_msk[i] = bus_wdata[i % BW];
                        REG_RISE:    rf_d.rise_en[i] = bus_wdata[i % BW];
                        REG_FALL:    rf_d.fall_en[i] = bus_wdata[i % BW];
                        REG_CAPT:    clr_d[i]        = bus_wdata[i % BW];
                        default:     ;
                    endcase
                end
            end
            if (int'(word) == 0) begin
                if (sel == REG_CTRL && bus_wmask[0]) begin
                    rf_d.swe = bus_wdata[0];
                end
                if (sel == REG_DEBLEN) begin
                    for (int b = 0; b < DB_BITS; b++) begin
                        if (bus_wmask[b]) rf_d.deblen[b] = bus_wdata[b];
                    end
                end
            end
        end
    end

    always_comb begin
        case (sel)
            REG_DRV:     rd_vec = rf_q.drv;
            REG_ALTSEL:  rd_vec = rf_q.altsel;
            REG_SAFEVAL: rd_vec = rf_q.safe_val;
            REG_SAFEMSK: rd_vec = rf_q.safe_msk;
            REG_RISE:    rd_vec = rf_q.rise_en;
            REG_FALL:    rd_vec = rf_q.fall_en;
            REG_CAPT:    rd_vec = cap;
            REG_LEVEL:   rd_vec = level;
            default:     rd_vec = '0;
        endcase
        bus_rdata = '0;
        for (int j = 0; j < BW; j++) begin
            if (int'(word) * BW + j < NCH) begin
                bus_rdata[j] = rd_vec[int'(word) * BW + j];
            end
        end
        if (int'(word) == 0) begin
            if (sel == REG_CTRL) begin
                bus_rdata[0] = rf_q.swe;
            end
            if (sel == REG_DEBLEN) begin
                for (int b = 0; b < DB_BITS; b++) bus_rdata[b] = rf_q.deblen[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign drv_o      = rf_q.drv;
    assign altsel_o   = rf_q.altsel;
    assign safe_val_o = rf_q.safe_val;
    assign safe_msk_o = rf_q.safe_msk;
    assign rise_en_o  = rf_q.rise_en;
    assign fall_en_o  = rf_q.fall_en;
    assign swe_o      = rf_q.swe;
    assign deblen_o   = rf_q.deblen;
    assign cap_clr_o  = clr_d;

endmodule

// File: rtl/dio_drive.sv
module dio_drive #(
    parameter int NCH = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] drv,
    input  logic [NCH-1:0] altsel,
    input  logic [NCH-1:0] alt_src,
    input  logic [NCH-1:0] safe_val,
    input  logic [NCH-1:0] safe_msk,
    input  logic           safe_active,
    output logic [NCH-1:0] pull_low
);

    logic [NCH-1:0] normal;
    logic [NCH-1:0] override;
    logic [NCH-1:0] drive_d, drive_q;

    always_comb begin
        normal   = (altsel & alt_src) | (~altsel & drv);
        override = {NCH{safe_active}} & safe_msk;
        drive_d  = (override & safe_val) | (~override & normal);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
        end else begin
            drive_q <= drive_d;
        end
    end

    assign pull_low = drive_q;

endmodule

// File: rtl/dio_filter_lane.sv
module dio_filter_lane #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic             pad_in,
    input  logic [CNT_W-1:0] deblen,
    output logic             samp_o,
    output logic             level_o
);

    typedef struct packed {
        logic             samp;
        logic             filt;
        logic [CNT_W-1:0] cnt;
    } lane_t;

    lane_t           ln_d, ln_q;
    logic [CNT_W:0]  cnt_next;

    always_comb begin
        ln_d     = ln_q;
        cnt_next = {1'b0, ln_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (sample_tick) begin
            ln_d.samp = ~pad_in;
        end
        if (deblen == '0) begin
            ln_d.filt = ln_q.samp;
            ln_d.cnt  = '0;
        end else if (sample_tick) begin
            if (ln_q.samp == ln_q.filt) begin
                ln_d.cnt = '0;
            end else if (cnt_next >= {1'b0, deblen}) begin
                ln_d.filt = ln_q.samp;
                ln_d.cnt  = '0;
            end else begin
                ln_d.cnt = cnt_next[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign samp_o  = ln_q.samp;
    assign level_o = ln_q.filt;

endmodule

// File: rtl/dio_edge_capture.sv
module dio_edge_capture #(
    parameter int NCH = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] level,
    input  logic [NCH-1:0] rise_en,
    input  logic [NCH-1:0] fall_en,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] cap_o,
    output logic           irq
);

    typedef struct packed {
        logic [NCH-1:0] prev;
        logic [NCH-1:0] cap;
    } ec_t;

    ec_t            ec_d, ec_q;
    logic [NCH-1:0] rise, fall;

    always_comb begin
        rise      = level & ~ec_q.prev;
        fall      = ~level & ec_q.prev;
        ec_d.prev = level;
        ec_d.cap  = (ec_q.cap & ~clr) | (rise & rise_en) | (fall & fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ec_q <= '0;
        end else begin
            ec_q <= ec_d;
        end
    end

    assign cap_o = ec_q.cap;
    assign irq   = |(ec_q.cap & (rise_en | fall_en));

endmodule

// File: rtl/dio_bank.sv
module dio_bank
    import dio_pkg::*;
#(
    parameter  int NCH    = 48,
    parameter  int BW     = 32,
    parameter  int CNT_W  = 8,
    localparam int NW     = words_for(NCH, BW),
    localparam int WSEL_W = sel_width(NW),
    localparam int ADDR_W = REG_IDX_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    input  logic [BW-1:0]     bus_wmask,
    output logic [BW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    alt_src,
    input  logic              safe_active,
    input  logic              sample_tick,
    input  logic [NCH-1:0]    pad_in,
    output logic [NCH-1:0]    pad_pull_low,
    output logic              irq
);

    logic [NCH-1:0]   drv, altsel, safe_val, safe_msk, rise_en, fall_en;
    logic [NCH-1:0]   cap_q, cap_clr, level, samp_vec;
    logic             swe;
    logic [CNT_W-1:0] deblen;

    dio_regfile #(
        .NCH(NCH), .BW(BW), .CNT_W(CNT_W), .WSEL_W(WSEL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .level(level), .cap(cap_q),
        .drv_o(drv), .altsel_o(altsel),
        .safe_val_o(safe_val), .safe_msk_o(safe_msk),
        .rise_en_o(rise_en), .fall_en_o(fall_en),
        .swe_o(swe), .deblen_o(deblen), .cap_clr_o(cap_clr)
    );

    dio_drive #(.NCH(NCH)) u_drive (
        .clk(clk), .rst_n(rst_n),
        .drv(drv), .altsel(altsel), .alt_src(alt_src),
        .safe_val(safe_val), .safe_msk(safe_msk),
        .safe_active(safe_active), .pull_low(pad_pull_low)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        dio_filter_lane #(.CNT_W(CNT_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .sample_tick(sample_tick), .pad_in(pad_in[c]),
            .deblen(deblen), .samp_o(samp_vec[c]), .level_o(level[c])
        );
    end

    dio_edge_capture #(.NCH(NCH)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .level(level), .rise_en(rise_en), .fall_en(fall_en),
        .clr(cap_clr), .cap_o(cap_q), .irq(irq)
    );

endmodule

// File: rtl/dio_bank_chk.sv
module dio_bank_chk
    import dio_pkg::*;
#(
    parameter  int NCH    = 48,
    parameter  int BW     = 32,
    parameter  int CNT_W  = 8,
    localparam int NW     = words_for(NCH, BW),
    localparam int WSEL_W = sel_width(NW),
    localparam int ADDR_W = REG_IDX_W + WSEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              safe_active,
    input logic              sample_tick,
    input logic [NCH-1:0]    pad_pull_low,
    input logic              irq,
    input logic [NCH-1:0]    cap_q,
    input logic [NCH-1:0]    safe_val,
    input logic [NCH-1:0]    safe_msk,
    input logic              swe,
    input logic [NCH-1:0]    samp_vec,
    input logic [NCH-1:0]    level,
    input logic [CNT_W-1:0]  deblen
);

    logic [REG_IDX_W-1:0] idx;
    logic                 wr_capt, wr_safe;

    assign idx     = bus_addr[ADDR_W-1:WSEL_W];
    assign wr_capt = bus_we && (idx == REG_CAPT);
    assign wr_safe = bus_we && (idx == REG_SAFEVAL || idx == REG_SAFEMSK);

    AST_SAFE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        safe_active |=> ((pad_pull_low & $past(safe_msk)) == ($past(safe_val) & $past(safe_msk)))); // R5

    AST_SAFE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_safe && !swe) |=> ($stable(safe_val) && $stable(safe_msk))); // R6

    AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && deblen != '0) |=> $stable(level)); // R7

    AST_CAPTURE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_capt |=> ((cap_q & $past(cap_q)) == $past(cap_q))); // R8

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cap_q != '0)); // R10

    AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(samp_vec)); // R11

endmodule

bind dio_bank dio_bank_chk #(.NCH(NCH), .BW(BW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .safe_active(safe_active), .sample_tick(sample_tick),
    .pad_pull_low(pad_pull_low), .irq(irq), .cap_q(cap_q),
    .safe_val(safe_val), .safe_msk(safe_msk), .swe(swe),
    .samp_vec(samp_vec), .level(level), .deblen(deblen)
);

// File: tb/dio_bank_tb.sv
module dio_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int BW = 4;
    localparam int CNT_W = 4;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BW-1:0]     bus_wdata = '0;
    logic [BW-1:0]     bus_wmask = '0;
    logic [BW-1:0]     bus_rdata;
    logic [NCH-1:0]    alt_src = '0;
    logic              safe_active = 1'b0;
    logic              sample_tick = 1'b0;
    logic [NCH-1:0]    pad_in;
    logic [NCH-1:0]    pad_pull_low;
    logic              irq;
    logic [NCH-1:0]    ext_low = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pad_in = ~(pad_pull_low | ext_low);

    dio_bank #(.NCH(NCH), .BW(BW), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .alt_src(alt_src), .safe_active(safe_active), .sample_tick(sample_tick),
        .pad_in(pad_in), .pad_pull_low(pad_pull_low), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int r, input int w, input logic [3:0] d, input logic [3:0] m);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = {4'(r), 1'(w)};
        bus_wdata = d;
        bus_wmask = m;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic wr8(input int r, input logic [7:0] d, input logic [7:0] m);
        wr(r, 0, d[3:0], m[3:0]);
        wr(r, 1, d[7:4], m[7:4]);
    endtask

    task automatic rd8(input int r, output logic [7:0] v);
        bus_addr = {4'(r), 1'b0};
        #1 v[3:0] = bus_rdata;
        bus_addr = {4'(r), 1'b1};
        #1 v[7:4] = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic settle();
        tick();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, out_m, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pull_low", pad_pull_low, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        for (int r = 0; r < 10; r++) begin
            rd8(r, v);
            chk($sformatf("R1 reg%0d", r), v, 8'h00);
        end

        // R2 masked write sweep on output latch
        out_m = 8'h00;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] m;
            m = 8'((i * 73 + 11) & 255);
            out_m = (out_m & ~m) | (8'(i) & m);
            wr8(0, 8'(i), m);
            @(negedge clk);
            chk("R2 drive", pad_pull_low, out_m);
        end

        // R3 readback is wired-AND of own and external pull-downs
        for (int a = 0; a < 256; a += 17) begin
            for (int e = 0; e < 256; e += 51) begin
                ext_low = 8'(e);
                wr8(0, 8'(a), 8'hFF);
                settle();
                rd8(7, v);
                chk("R3 level", v, 8'(a) | 8'(e));
            end
        end
        ext_low = 8'h00;

        // R4 alternate source
        wr8(0, 8'h33, 8'hFF);
        wr8(1, 8'hA5, 8'hFF);
        for (int a = 0; a < 256; a += 7) begin
            @(negedge clk);
            alt_src = 8'(a);
            @(negedge clk);
            @(negedge clk);
            chk("R4 alt drive", pad_pull_low, (8'(a) & 8'hA5) | (8'h33 & 8'h5A));
        end
        wr8(1, 8'h00, 8'hFF);

        // R5 safe override
        wr8(0, 8'h55, 8'hFF);
        wr(8, 0, 4'h1, 4'h1);
        wr8(2, 8'h3C, 8'hFF);
        wr8(3, 8'h0F, 8'hFF);
        @(negedge clk);
        chk("R5 inactive", pad_pull_low, 8'h55);
        safe_active = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 active", pad_pull_low, 8'h5C);

        // R6 protected safe registers
        wr(8, 0, 4'h0, 4'h1);
        wr8(2, 8'hFF, 8'hFF);
        wr8(3, 8'hFF, 8'hFF);
        rd8(2, v);
        chk("R6 safe value", v, 8'h3C);
        rd8(3, v);
        chk("R6 safe enable", v, 8'h0F);
        @(negedge clk);
        chk("R6 drive", pad_pull_low, 8'h5C);
        safe_active = 1'b0;
        wr8(0, 8'h00, 8'hFF);
        settle();
        rd8(7, v);
        chk("R3 idle level", v, 8'h00);

        // R7 debounce timing and restart
        wr(9, 0, 4'h3, 4'hF);
        ext_low = 8'h04;
        for (int t = 1; t <= 3; t++) begin
            tick();
            rd8(7, v);
            chk($sformatf("R7 before accept t%0d", t), v, 8'h00);
        end
        tick();
        rd8(7, v);
        chk("R7 accepted", v, 8'h04);
        ext_low = 8'h00;
        tick();
        tick();
        ext_low = 8'h04;
        tick();
        tick();
        tick();
        tick();
        rd8(7, v);
        chk("R7 bounce rejected", v, 8'h04);
        wr(9, 0, 4'h0, 4'hF);

        // R11 no sampling without strobe
        ext_low = 8'h81;
        repeat (6) @(negedge clk);
        rd8(7, v);
        chk("R11 held", v, 8'h04);
        settle();
        rd8(7, v);
        chk("R11 sampled", v, 8'h81);

        // R8 edge capture
        ext_low = 8'h00;
        settle();
        wr8(6, 8'hFF, 8'hFF);
        wr8(4, 8'h0F, 8'hFF);
        wr8(5, 8'hF0, 8'hFF);
        rd8(6, v);
        chk("R8 cleared", v, 8'h00);
        ext_low = 8'hFF;
        settle();
        @(negedge clk);
        rd8(6, v);
        chk("R8 rise", v, 8'h0F);
        chk("R10 irq set", {7'd0, irq}, 8'h01);
        ext_low = 8'h00;
        settle();
        @(negedge clk);
        rd8(6, v);
        chk("R8 fall", v, 8'hFF);

        // R9 write-one-to-clear
        wr(6, 0, 4'h5, 4'hF);
        rd8(6, v);
        chk("R9 clear ones", v, 8'hFA);
        wr(6, 1, 4'h0, 4'hF);
        wr(6, 1, 4'hF, 4'h0);
        rd8(6, v);
        chk("R9 zero/masked", v, 8'hFA);
        wr(6, 1, 4'h3, 4'h1);
        rd8(6, v);
        chk("R9 partial mask", v, 8'hEA);

        // R10 interrupt gated by enables
        wr8(4, 8'h00, 8'hFF);
        wr8(5, 8'h00, 8'hFF);
        chk("R10 disabled", {7'd0, irq}, 8'h00);
        rd8(6, v);
        chk("R10 flags kept", v, 8'hEA);
        wr8(5, 8'h80, 8'h80);
        chk("R10 one enabled", {7'd0, irq}, 8'h01);
        wr8(6, 8'hFF, 8'hFF);
        chk("R10 all cleared", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule